// File: doc/BRIEF.md
# SCSI Controller Command and Interrupt Register Front End

This block is the host-side register bank of a simple SCSI protocol controller. A byte-wide bus reaches sixteen byte registers. At most offsets a read and a write reach different storage: a read sees a status view and a write sets a control view. Each write to the command register is decoded at once. The command updates the status, interrupt-reason, sequence-step and FIFO-flag registers. It may also raise the level interrupt output, which is simply bit 7 of the status register.

The actual bus phases, target lookup and DMA memory traffic belong to a separate sequencer. For the three selection commands this block only sends that sequencer a one-cycle start strobe and a code for the kind of selection. Host software clears the interrupt by reading the interrupt-reason register. That read returns the old reason and also resets part of the status and the sequence step.

Register offsets: 0 count low, 1 count mid, 2 count high, 3 command, 4 status (read), 5 interrupt reason (read), 6 sequence step (read), 7 FIFO flags (read), 8 configuration 1. Offsets 9 to 15 read back what was written to them.

Top module: `scsi_cmd_regs`

## Requirements
- R1: `irq` always equals status bit 7. It rises only in the cycle after a command write. A command that raises it while it is already high leaves it high, and one reason read then lowers it.
- R2: A read of offset 5 returns the old reason in the next cycle. The same read clears the reason to 0x00, clears status bit 4 (terminal count) and status bit 7, and sets the sequence step to 0x04.
- R3: The command code is bits 6:0 of the command byte. When bit 7 is set, the read views of count low and count mid are also reloaded from their write views.
- R4: Flush (0x01) sets the reason to 0x08 and clears the sequence step and the FIFO flags. It does not change `irq`.
- R5: SCSI bus reset (0x03) sets reason bit 7 (0x80). It raises `irq` only when configuration-1 bit 6 is 0.
- R6: Message accepted (0x12) sets the reason to 0x20, clears the sequence step and the FIFO flags, and raises `irq`.
- R7: Initiator command complete (0x11) sets the reason to 0x08, sets status bits 2:0 to 3'b111 and raises `irq`.
- R8: Pad (0x18) sets the status to 0x90 (terminal count plus interrupt), sets the reason to 0x08 and clears the sequence step.
- R9: Enable selection (0x44) clears the reason. Selection commands 0x41, 0x42 and 0x43 pulse `sel_go` for one cycle, with `sel_kind` set to 1, 2 and 3. Set-ATN (0x1a) and no-op (0x00) change no readable register.
- R10: Any other code changes nothing except reason bit 6 (0x40). That bit stays set through later commands that write the reason. Only a reason read, enable selection or chip reset clears it.
- R11: Synchronous reset, and the chip reset command (0x02), zero every register except two. Count high reads 0x04 and configuration 1 reads 0x07. `irq` goes low.
- R12: The register offset is bits [STRIDE+3:STRIDE] of `addr`. Address bits below STRIDE are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (read side effects apply) |
| rd_data | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt, status bit 7 |
| sel_go | output | 1 | One-cycle start strobe to the selection sequencer |
| sel_kind | output | 2 | Kind of selection requested with `sel_go` |

## Verification
The assertions check the following on every cycle:
- the interrupt only ever rises after a command write;
- a reason read always leaves the reason cleared, the interrupt low and the step at the command-phase value;
- a masked bus reset never raises the interrupt;
- the selection strobe only follows a command write;
- the illegal-command flag stays set until one of its three clearing events.

Only the bench scenarios can show the following:
- the exact values each command leaves in the readable registers;
- the returned old reason value;
- the count reload and the address stride;
- the reset constants restored by the chip reset command.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;
  localparam int unsigned NUM_REGS  = 16;
  localparam int unsigned REG_IDX_W = $clog2(NUM_REGS);

  localparam logic [REG_IDX_W-1:0] OFF_CNT_LO = 4'd0;
  localparam logic [REG_IDX_W-1:0] OFF_CNT_MD = 4'd1;
  localparam logic [REG_IDX_W-1:0] OFF_CNT_HI = 4'd2;
  localparam logic [REG_IDX_W-1:0] OFF_CMD    = 4'd3;
  localparam logic [REG_IDX_W-1:0] OFF_STAT   = 4'd4;
  localparam logic [REG_IDX_W-1:0] OFF_WHY    = 4'd5;
  localparam logic [REG_IDX_W-1:0] OFF_STEP   = 4'd6;
  localparam logic [REG_IDX_W-1:0] OFF_FLAGS  = 4'd7;
  localparam logic [REG_IDX_W-1:0] OFF_CFG1   = 4'd8;

  localparam int unsigned ST_INT_BIT = 7;
  localparam int unsigned ST_TC_BIT  = 4;
  localparam logic [7:0]  ST_PHASE_ALL = 8'h07;

  localparam logic [7:0] WHY_BUSRST = 8'h80;
  localparam logic [7:0] WHY_ILL    = 8'h40;
  localparam logic [7:0] WHY_DISC   = 8'h20;
  localparam logic [7:0] WHY_FDONE  = 8'h08;

  localparam logic [7:0] STEP_CMDPH  = 8'h04;
  localparam logic [7:0] CHIP_ID     = 8'h04;
  localparam logic [7:0] CFG1_RST    = 8'h07;
  localparam int unsigned CFG1_NORPT_BIT = 6;

  typedef enum logic [3:0] {
    K_NOP, K_FLUSH, K_CHIPRST, K_BUSRST, K_ICCS, K_MSGACC, K_PAD,
    K_SETATN, K_SEL, K_SELATN, K_SELSTOP, K_ENSEL, K_ILLEGAL
  } cmd_kind_e;
endpackage

// File: rtl/scsi_rf_addr_dec.sv
module scsi_rf_addr_dec #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STRIDE = 2,
  localparam int unsigned IDX_W = scsi_rf_pkg::REG_IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  initial begin
    if (ADDR_W < STRIDE + IDX_W) $error("address too narrow for stride");
  end
  assign idx = addr[STRIDE +: IDX_W];
endmodule

// File: rtl/scsi_rf_cmd_dec.sv
module scsi_rf_cmd_dec
  import scsi_rf_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output cmd_kind_e  kind,
  output logic       dma_reload
);
  logic [6:0] code;
  assign code       = cmd_byte[6:0];
  assign dma_reload = cmd_byte[7];

  always_comb begin
    unique case (code)
      7'h00:   kind = K_NOP;
      7'h01:   kind = K_FLUSH;
      7'h02:   kind = K_CHIPRST;
      7'h03:   kind = K_BUSRST;
      7'h11:   kind = K_ICCS;
      7'h12:   kind = K_MSGACC;
      7'h18:   kind = K_PAD;
      7'h1a:   kind = K_SETATN;
      7'h41:   kind = K_SEL;
      7'h42:   kind = K_SELATN;
      7'h43:   kind = K_SELSTOP;
      7'h44:   kind = K_ENSEL;
      default: kind = K_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs
  import scsi_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STRIDE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              irq,
  output logic              sel_go,
  output logic [1:0]        sel_kind
);
  localparam int unsigned IDX_W = REG_IDX_W;

  logic [IDX_W-1:0] idx;
  cmd_kind_e        kind;
  logic             dma_reload;

  scsi_rf_addr_dec #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_adec (
    .addr (addr),
    .idx  (idx)
  );

  scsi_rf_cmd_dec u_cdec (
    .cmd_byte   (wr_data),
    .kind       (kind),
    .dma_reload (dma_reload)
  );

  // Write view (control side) and read-only status side
  logic [7:0] wview [NUM_REGS];
  logic [7:0] status_q, why_q, step_q, flags_q;
  logic [7:0] cnt_lo_q, cnt_md_q, cnt_hi_q;
  logic [7:0] rd_mux;

  logic cmd_wr, why_rd, soft_rst;
  assign cmd_wr   = wr_en && (idx == OFF_CMD);
  assign why_rd   = rd_en && (idx == OFF_WHY);
  assign soft_rst = cmd_wr && (kind == K_CHIPRST);

  always_comb begin
    unique case (idx)
      OFF_CNT_LO: rd_mux = cnt_lo_q;
      OFF_CNT_MD: rd_mux = cnt_md_q;
      OFF_CNT_HI: rd_mux = cnt_hi_q;
      OFF_STAT:   rd_mux = status_q;
      OFF_WHY:    rd_mux = why_q;
      OFF_STEP:   rd_mux = step_q;
      OFF_FLAGS:  rd_mux = flags_q;
      default:    rd_mux = wview[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      for (int i = 0; i < NUM_REGS; i++) wview[i] <= 8'h00;
      wview[OFF_CFG1] <= CFG1_RST;
      status_q <= 8'h00;
      why_q    <= 8'h00;
      step_q   <= 8'h00;
      flags_q  <= 8'h00;
      cnt_lo_q <= 8'h00;
      cnt_md_q <= 8'h00;
      cnt_hi_q <= CHIP_ID;
      rd_data  <= 8'h00;
      sel_go   <= 1'b0;
      sel_kind <= 2'd0;
    end else begin
      sel_go <= 1'b0;
      if (wr_en) wview[idx] <= wr_data;
      if (rd_en) rd_data <= rd_mux;
      if (why_rd) begin
        why_q                <= 8'h00;
        status_q[ST_TC_BIT]  <= 1'b0;
        status_q[ST_INT_BIT] <= 1'b0;
        step_q               <= STEP_CMDPH;
      end
      if (cmd_wr) begin
        if (dma_reload) begin
          cnt_lo_q <= wview[OFF_CNT_LO];
          cnt_md_q <= wview[OFF_CNT_MD];
        end
        unique case (kind)
          K_FLUSH: begin
            why_q   <= WHY_FDONE | (why_q & WHY_ILL);
            step_q  <= 8'h00;
            flags_q <= 8'h00;
          end
          K_BUSRST: begin
            why_q <= WHY_BUSRST | (why_q & WHY_ILL);
            if (!wview[OFF_CFG1][CFG1_NORPT_BIT]) status_q[ST_INT_BIT] <= 1'b1;
          end
          K_ICCS: begin
            why_q    <= WHY_FDONE | (why_q & WHY_ILL);
            status_q <= status_q | ST_PHASE_ALL | 8'h80;
          end
          K_MSGACC: begin
            why_q    <= WHY_DISC | (why_q & WHY_ILL);
            step_q   <= 8'h00;
            flags_q  <= 8'h00;
            status_q[ST_INT_BIT] <= 1'b1;
          end
          K_PAD: begin
            status_q <= 8'h90;
            why_q    <= WHY_FDONE | (why_q & WHY_ILL);
            step_q   <= 8'h00;
          end
          K_SEL: begin
            sel_go <= 1'b1; sel_kind <= 2'd1;
          end
          K_SELATN: begin
            sel_go <= 1'b1; sel_kind <= 2'd2;
          end
          K_SELSTOP: begin
            sel_go <= 1'b1; sel_kind <= 2'd3;
          end
          K_ENSEL:   why_q <= 8'h00;
          K_ILLEGAL: why_q <= why_q | WHY_ILL;
          default: ;
        endcase
      end
    end
  end

  assign irq = status_q[ST_INT_BIT];

  AST_IRQ_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(cmd_wr)); // R1

  AST_WHY_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    why_rd |=> (why_q == 8'h00 && !irq && step_q == STEP_CMDPH)); // R2

  AST_BUSRST_MASKED: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && kind == K_BUSRST && wview[OFF_CFG1][CFG1_NORPT_BIT] && !irq) |=> !irq); // R5

  AST_SEL_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    sel_go |-> $past(cmd_wr)); // R9

  AST_ILL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (why_q[6] && !why_rd && !(cmd_wr && (kind == K_ENSEL || kind == K_CHIPRST)))
      |=> why_q[6]); // R10
endmodule

// File: tb/test_scsi_cmd_regs.sv
module test_scsi_cmd_regs;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned STRIDE = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_data = 8'h00;
  logic              rd_en = 1'b0;
  logic [7:0]        rd_data;
  logic              irq, sel_go;
  logic [1:0]        sel_kind;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  scsi_cmd_regs #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) i_scsi_cmd_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .sel_go(sel_go),
    .sel_kind(sel_kind)
  );

  // scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_d = 1'b0;

  always @(posedge clk) rd_d <= rd_en;

  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rd_data !== e) begin
        n_bad++;
        $display("FAIL %s: read got %02h expected %02h", t, rd_data, e);
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", t, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input int i, input logic [7:0] d);
    wr_raw(ADDR_W'(i << STRIDE), d);
  endtask

  task automatic rd_raw(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd(input int i, input logic [7:0] e, input string t);
    rd_raw(ADDR_W'(i << STRIDE), e, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk({7'd0, irq}, 8'h00, "R11 irq after reset");
    rd(2, 8'h04, "R11 count high id");
    rd(8, 8'h07, "R11 cfg1 default");
    rd(4, 8'h00, "R11 status zero");
    // R5 bus reset reported, R1 double raise
    wr(3, 8'h03);
    chk({7'd0, irq}, 8'h01, "R5 irq raised");
    wr(3, 8'h03);
    chk({7'd0, irq}, 8'h01, "R1 irq stays set");
    rd(5, 8'h80, "R2 reason old value");
    chk({7'd0, irq}, 8'h00, "R1 irq lowered by read");
    rd(4, 8'h00, "R2 status cleared");
    rd(6, 8'h04, "R2 step command phase");
    rd(5, 8'h00, "R2 reason cleared");
    // R5 masked
    wr(8, 8'h47);
    wr(3, 8'h03);
    chk({7'd0, irq}, 8'h00, "R5 masked no irq");
    rd(5, 8'h80, "R5 reason set when masked");
    rd(8, 8'h47, "R5 cfg1 readback");
    // R4 flush
    wr(3, 8'h01);
    chk({7'd0, irq}, 8'h00, "R4 no irq");
    rd(6, 8'h00, "R4 step cleared");
    rd(7, 8'h00, "R4 flags cleared");
    rd(5, 8'h08, "R4 reason fdone");
    // R6 message accepted
    wr(3, 8'h12);
    chk({7'd0, irq}, 8'h01, "R6 irq");
    rd(6, 8'h00, "R6 step cleared");
    rd(5, 8'h20, "R6 reason disconnect");
    // R7 initiator complete
    wr(3, 8'h11);
    chk({7'd0, irq}, 8'h01, "R7 irq");
    rd(4, 8'h87, "R7 status phase+int");
    rd(5, 8'h08, "R7 reason fdone");
    rd(4, 8'h07, "R7 status after read");
    // R8 pad
    wr(3, 8'h18);
    chk({7'd0, irq}, 8'h01, "R8 irq");
    rd(4, 8'h90, "R8 status");
    rd(6, 8'h00, "R8 step");
    rd(5, 8'h08, "R8 reason");
    rd(4, 8'h00, "R8 status after read");
    // R10 illegal sticky
    wr(3, 8'h55);
    chk({7'd0, irq}, 8'h00, "R10 no irq");
    wr(3, 8'h01);
    rd(5, 8'h48, "R10 sticky through flush");
    rd(5, 8'h00, "R10 cleared by read");
    // R9 enable selection clears
    wr(3, 8'h55);
    wr(3, 8'h44);
    rd(5, 8'h00, "R9 enable selection clears");
    // R9 selection strobes
    wr(3, 8'h42);
    chk({6'd0, sel_kind}, 8'h02, "R9 sel kind atn");
    chk({7'd0, sel_go}, 8'h01, "R9 sel_go pulse");
    @(negedge clk);
    chk({7'd0, sel_go}, 8'h00, "R9 sel_go one cycle");
    wr(3, 8'h43);
    chk({6'd0, sel_kind}, 8'h03, "R9 sel kind stop");
    wr(3, 8'h41);
    chk({6'd0, sel_kind}, 8'h01, "R9 sel kind plain");
    wr(3, 8'h1a);
    rd(4, 8'h00, "R9 set ATN no status change");
    rd(5, 8'h00, "R9 set ATN no reason change");
    // R3 DMA reload with flush code
    wr(0, 8'h34);
    wr(1, 8'h12);
    rd(0, 8'h00, "R3 count not yet loaded");
    wr(3, 8'h81);
    rd(0, 8'h34, "R3 count low reloaded");
    rd(1, 8'h12, "R3 count mid reloaded");
    rd(5, 8'h08, "R3 code from low bits");
    // R12 stride
    wr_raw(ADDR_W'((9 << STRIDE) | 3), 8'h5a);
    rd_raw(ADDR_W'(9 << STRIDE), 8'h5a, "R12 low address bits ignored");
    // R11 chip reset command
    wr(8, 8'h47);
    wr(3, 8'h12);
    chk({7'd0, irq}, 8'h01, "R11 irq before chip reset");
    wr(3, 8'h02);
    chk({7'd0, irq}, 8'h00, "R11 irq after chip reset");
    rd(8, 8'h07, "R11 cfg1 restored");
    rd(2, 8'h04, "R11 id restored");
    rd(0, 8'h00, "R11 count low zeroed");
    rd(9, 8'h00, "R11 general reg zeroed");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule